// File: doc/BRIEF.md
# Two-Level Page Permission Checker

This block decides whether one memory access may proceed. It looks only at the protection flags of two paging entries: the upper-level directory entry and the lower-level table entry. It weighs those flags against the current privilege level, the access kind (read or write) and a stored write-protect control bit. A request is presented on one clock edge, and a registered verdict follows one cycle later. The verdict is either a grant, or a fault with a two-bit reason code.

The two levels are merged into the more restrictive of the two. The page counts as user-accessible only if both entries mark it user. It counts as writable only if both entries mark it writable. Privilege levels 0 to 2 run in supervisor mode and level 3 runs in user mode.

Supervisor writes normally ignore read-only marks. They become subject to the writable check only while the write-protect bit is set. That bit is held inside the block, is cleared by reset and is loaded through a separate control strobe.

The block does not walk page tables, check present bits, cache translations or apply segmentation.

Top module: `page_perm_check`

## Requirements
- R1: A request sampled with `req_vld` high produces `rsp_vld` high for exactly one cycle on the following clock edge. With no request in a cycle, `rsp_vld`, `rsp_grant`, `rsp_fault` and `rsp_reason` are all 0 after the next edge.
- R2: In each entry, bit 1 is the writable flag (1 = read/write, 0 = read-only) and bit 2 is the user flag (1 = user page, 0 = supervisor page). All other entry bits have no effect on the result.
- R3: A `cur_priv` value of 0, 1 or 2 selects supervisor mode. A value of 3 selects user mode.
- R4: In supervisor mode, a read is always granted, whatever the flags of either entry.
- R5: In user mode, any access to a page whose user flag is 0 in either entry faults with reason 2'b01 (privilege).
- R6: In user mode, a write is granted only if both entries have user flag 1 and writable flag 1. A write to a user page that is not writable at both levels faults with reason 2'b10 (read-only).
- R7: While the write-protect bit is 0, supervisor writes are granted regardless of the writable flags.
- R8: While the write-protect bit is 1, a supervisor write to a page that is not writable at both levels faults with reason 2'b10.
- R9: The write-protect bit is 0 after reset. It takes the value of `ctl_wp` on an edge where `ctl_wr` is 1. A request in that same cycle is judged with the value held before the write.
- R10: When a user-mode access fails both the privilege check and the writable check, the reason is 2'b01.
- R11: While `rsp_vld` is 1, exactly one of `rsp_grant` and `rsp_fault` is 1. `rsp_fault` is 1 exactly when `rsp_reason` is nonzero, and the reason is 2'b00 on a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Request strobe for the current cycle |
| dir_entry | input | 32 | Upper-level (directory) entry |
| tbl_entry | input | 32 | Lower-level (table) entry |
| cur_priv | input | 2 | Current privilege level |
| is_write | input | 1 | 1 = write access, 0 = read access |
| ctl_wr | input | 1 | Load strobe for the write-protect bit |
| ctl_wp | input | 1 | New write-protect value |
| rsp_vld | output | 1 | Verdict valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied |
| rsp_reason | output | 2 | 00 none, 01 privilege, 10 read-only |

## Verification
Every verdict is due exactly one edge after its request. The bench drives the inputs on the falling edge and computes the expected verdict from those inputs and its own copy of the write-protect bit. It then samples the outputs two nanoseconds after the next rising edge and compares them there.

A write-protect load takes effect at the same edge that registers the verdict of any request in that cycle. For that reason, the bench updates its model bit only after it has computed the expected verdict for that cycle. Idle cycles are checked at the same sampling point, so that the outputs are seen to return to zero.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    typedef enum logic [1:0] {
        RSN_NONE   = 2'b00,
        RSN_PRIV   = 2'b01,
        RSN_RDONLY = 2'b10
    } reason_e;

    typedef struct packed {
        logic    vld;
        logic    grant;
        reason_e reason;
        logic    wp;
    } chk_state_t;

endpackage

// File: rtl/pchk_level_merge.sv
// Folds the protection flags of all paging levels into the most restrictive set.
module pchk_level_merge #(
    parameter int LEVELS  = 2,
    parameter int ENTRY_W = 32,
    parameter int RW_BIT  = 1,
    parameter int US_BIT  = 2
) (
    input  logic [LEVELS-1:0][ENTRY_W-1:0] entries,
    output logic                           eff_user,
    output logic                           eff_write
);
    logic [LEVELS:0] user_chain;
    logic [LEVELS:0] write_chain;

    assign user_chain[0]  = 1'b1;
    assign write_chain[0] = 1'b1;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        assign user_chain[lv+1]  = user_chain[lv]  & entries[lv][US_BIT];
        assign write_chain[lv+1] = write_chain[lv] & entries[lv][RW_BIT];
    end

    assign eff_user  = user_chain[LEVELS];
    assign eff_write = write_chain[LEVELS];
endmodule

// File: rtl/pchk_rule.sv
// Applies the mode rules to the merged flags and picks the fault reason.
module pchk_rule
    import pchk_pkg::*;
#(
    parameter int PRIV_W    = 2,
    parameter int USER_PRIV = 3
) (
    input  logic [PRIV_W-1:0] priv,
    input  logic              is_write,
    input  logic              wp,
    input  logic              eff_user,
    input  logic              eff_write,
    output reason_e           reason
);
    localparam logic [PRIV_W-1:0] USER_LVL = PRIV_W'(USER_PRIV);

    logic user_mode;
    logic wr_checked;

    assign user_mode  = (priv == USER_LVL);
    assign wr_checked = user_mode | wp;

    always_comb begin
        if (user_mode && !eff_user) begin
            reason = RSN_PRIV;
        end else if (is_write && !eff_write && wr_checked) begin
            reason = RSN_RDONLY;
        end else begin
            reason = RSN_NONE;
        end
    end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import pchk_pkg::*;
#(
    parameter int ENTRY_W   = 32,
    parameter int PRIV_W    = 2,
    parameter int RW_BIT    = 1,
    parameter int US_BIT    = 2,
    parameter int USER_PRIV = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_vld,
    input  logic [ENTRY_W-1:0] dir_entry,
    input  logic [ENTRY_W-1:0] tbl_entry,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               is_write,
    input  logic               ctl_wr,
    input  logic               ctl_wp,
    output logic               rsp_vld,
    output logic               rsp_grant,
    output logic               rsp_fault,
    output logic [1:0]         rsp_reason
);
    localparam int LEVELS = 2;
    localparam logic [PRIV_W-1:0] USER_LVL = PRIV_W'(USER_PRIV);

    chk_state_t st_d, st_q;
    logic       eff_user, eff_write;
    reason_e    reason;

    pchk_level_merge #(
        .LEVELS (LEVELS),
        .ENTRY_W(ENTRY_W),
        .RW_BIT (RW_BIT),
        .US_BIT (US_BIT)
    ) i_merge (
        .entries  ({tbl_entry, dir_entry}),
        .eff_user (eff_user),
        .eff_write(eff_write)
    );

    pchk_rule #(
        .PRIV_W   (PRIV_W),
        .USER_PRIV(USER_PRIV)
    ) i_rule (
        .priv     (cur_priv),
        .is_write (is_write),
        .wp       (st_q.wp),
        .eff_user (eff_user),
        .eff_write(eff_write),
        .reason   (reason)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = req_vld;
        st_d.grant  = req_vld && (reason == RSN_NONE);
        st_d.reason = req_vld ? reason : RSN_NONE;
        if (ctl_wr) begin
            st_d.wp = ctl_wp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, grant: 1'b0, reason: RSN_NONE, wp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_vld    = st_q.vld;
    assign rsp_grant  = st_q.grant;
    assign rsp_fault  = st_q.vld && (st_q.reason != RSN_NONE);
    assign rsp_reason = st_q.reason;

    // R1: a verdict follows every request one edge later
    a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    // R1: no request, no verdict
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && !rsp_grant && rsp_reason == 2'b00));

    // R4: supervisor reads always pass
    a_r4_sup_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_priv != USER_LVL && !is_write) |=> rsp_grant);

    // R5 / R10: user access to a non-user page is a privilege fault
    a_r5_user_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_priv == USER_LVL && !(dir_entry[US_BIT] && tbl_entry[US_BIT]))
        |=> (rsp_reason == 2'b01));

    // R7: with write-protect clear, supervisor writes pass
    a_r7_sup_write_free: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cur_priv != USER_LVL && is_write && !st_q.wp) |=> rsp_grant);

    // R11: grant and fault are exclusive and cover every verdict
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_grant != rsp_fault) && (rsp_grant == (rsp_reason == 2'b00)));
endmodule

// File: tb/test_page_perm_check.sv
`timescale 1ns/1ps
module test_page_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [31:0] dir_entry = '0;
    logic [31:0] tbl_entry = '0;
    logic [1:0]  cur_priv = '0;
    logic        is_write = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        ctl_wp = 1'b0;
    logic        rsp_vld, rsp_grant, rsp_fault;
    logic [1:0]  rsp_reason;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_wp = 0;

    always #4 clk = ~clk;

    page_perm_check i_page_perm_check (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
        .dir_entry(dir_entry), .tbl_entry(tbl_entry), .cur_priv(cur_priv),
        .is_write(is_write), .ctl_wr(ctl_wr), .ctl_wp(ctl_wp),
        .rsp_vld(rsp_vld), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
        .rsp_reason(rsp_reason)
    );

    function automatic logic [1:0] ref_reason(logic [31:0] d, logic [31:0] t,
                                              logic [1:0] p, logic w, bit wp);
        bit usr  = (p == 2'd3);
        bit upg  = d[2] && t[2];
        bit wpg  = d[1] && t[1];
        if (usr && !upg) return 2'b01;
        if (w && !wpg && (usr || wp)) return 2'b10;
        return 2'b00;
    endfunction

    task automatic check4(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s vld/grant/fault/reason got %b expected %b", tag, got, exp);
        end
    endtask

    // One cycle: drive on falling edge, predict, sample 2 ns after rising edge.
    task automatic cyc(string tag, bit rq, logic [31:0] d, logic [31:0] t,
                       logic [1:0] p, bit w, bit cw, bit cv);
        logic [1:0] er;
        logic [3:0] exp;
        @(negedge clk);
        req_vld = rq; dir_entry = d; tbl_entry = t; cur_priv = p;
        is_write = w; ctl_wr = cw; ctl_wp = cv;
        er  = rq ? ref_reason(d, t, p, w, model_wp) : 2'b00;
        exp = rq ? {1'b1, er == 2'b00, er != 2'b00, er} : 4'b0000;
        if (cw) model_wp = cv;
        @(posedge clk);
        #2;
        check4(tag, {rsp_vld, rsp_grant, rsp_fault, rsp_reason}, exp);
    endtask

    function automatic string tag_of(logic [1:0] p, bit w, logic [1:0] r);
        if (p == 2'd3) return (r == 2'b01) ? "R5" : "R6";
        if (!w) return "R4";
        return model_wp ? "R8" : "R7";
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check4("R1 reset", {rsp_vld, rsp_grant, rsp_fault, rsp_reason}, 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: write-protect clear after reset -> supervisor write to RO page passes
        cyc("R9 wp reset clear", 1, 32'h0000_0004, 32'h0000_0004, 2'd0, 1, 0, 0);
        // R1: idle cycle
        cyc("R1 idle", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1, 0, 0);
        // R3: level 2 is supervisor, reading a supervisor page
        cyc("R3 level2 sup", 1, 32'h0, 32'h0, 2'd2, 0, 0, 0);
        // R3: level 3 is user, same page faults
        cyc("R3 level3 user", 1, 32'h0, 32'h0, 2'd3, 0, 0, 0);
        // R2: other bits ignored (bits 1,2 clear, rest set)
        cyc("R2 other bits", 1, 32'hFFFF_FFF9, 32'hFFFF_FFF9, 2'd3, 0, 0, 0);
        // R2: only directory lacks user flag
        cyc("R2 dir user bit", 1, 32'h0000_0002, 32'h0000_0006, 2'd3, 0, 0, 0);
        // R10: user write to supervisor read-only page -> privilege
        cyc("R10 priority", 1, 32'h0, 32'h0000_0006, 2'd3, 1, 0, 0);
        // R9: same-cycle load; request uses old (clear) value -> grant
        cyc("R9 same cycle", 1, 32'h6, 32'h4, 2'd1, 1, 1, 1);
        // R8: now set -> fault read-only
        cyc("R8 wp set", 1, 32'h6, 32'h4, 2'd1, 1, 0, 0);
        // R11: grant case and fault case exclusivity via full compare
        cyc("R11 grant", 1, 32'h6, 32'h6, 2'd3, 1, 0, 0);
        cyc("R11 fault", 1, 32'h4, 32'h6, 2'd3, 1, 0, 0);
        // R6: user read on user RO page passes
        cyc("R6 user read ro", 1, 32'h4, 32'h4, 2'd3, 0, 0, 0);

        // Exhaustive sweep of mode, access, write-protect and flags
        for (int wpv = 0; wpv < 2; wpv++) begin
            cyc("R9 load", 0, 32'h0, 32'h0, 2'd0, 0, 1, wpv[0]);
            for (int p = 0; p < 4; p++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int df = 0; df < 4; df++) begin
                        for (int tf = 0; tf < 4; tf++) begin
                            logic [31:0] d, t;
                            logic [1:0] r;
                            d = {$urandom} & 32'hFFFF_FFF9 | (32'(df) << 1);
                            t = {$urandom} & 32'hFFFF_FFF9 | (32'(tf) << 1);
                            r = ref_reason(d, t, p[1:0], w[0], model_wp);
                            cyc(tag_of(p[1:0], w[0], r), 1, d, t, p[1:0], w[0], 0, 0);
                        end
                    end
                end
            end
        end
        cyc("R1 final idle", 0, 32'h0, 32'h0, 2'd0, 0, 0, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule